// File: doc/BRIEF.md
# Masked Content Search Engine

This block scans a stream of fixed-length storage blocks and compares each one, word by word, against a stored search pattern. A per-bit mask picks which bits take part in the compare, so a search can key on single bits, characters or whole fields anywhere in a block. After a start command the engine runs through one full pass of the storage (a fixed number of blocks) with no further help from the host, emits one match event per block that agrees with the pattern, and then raises a completion flag that the host uses as an interrupt.

Alongside the search, the block keeps one obsolete flag per storage block. The host tags or untags blocks, and the engine always presents the lowest-numbered obsolete block as the slot where the next write of new data should go, or reports that no such slot exists. Obsolete blocks stay visible to the content search.

Top module: `msrch_top`

## Requirements
- R1: A pattern bit whose mask bit is 0 takes no part in the compare; with every mask bit 0 every block in the pass matches. A mask bit of 1 means the block bit must equal the pattern bit.
- R2: A block matches only when every word of the block agrees with the pattern in all unmasked bits; a disagreement in any single word (first, middle or last) suppresses the match for that block.
- R3: Pattern and mask word k apply to the k-th word of the block, counting from 0 at the word flagged as start of block.
- R4: A match event (`match_vld` high for one cycle) appears in the cycle right after the clock edge that samples the block's end-of-block word; blocks may arrive back to back or with idle cycles between words.
- R5: When the address-report option is set at the start command, `match_addr` carries the block address sampled with the start-of-block word; with the option clear, `match_addr` is 0.
- R6: After `srch_start`, the search stops by itself once NUM_BLK blocks have been compared; `srch_done` then goes to 1 and stays there until the next `srch_start`, which clears it.
- R7: Blocks streamed while no search is running (before a start or after `srch_stop`) give no match event; a stopped search never raises `srch_done`.
- R8: A tag command with `tag_obsolete`=1 marks a block obsolete and with 0 clears the mark; from the next cycle on, `free_addr` shows the lowest-numbered obsolete block.
- R9: When no block is obsolete, `free_none` is 1 and `free_addr` is 0.
- R10: Obsolete marks have no effect on the content search.
- R11: After reset no block is obsolete, no search runs, `match_vld` and `srch_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Write one pattern/mask word |
| cfg_idx | input | IDX_W | Word position being written |
| cfg_pat | input | WORD_W | Pattern word |
| cfg_mask | input | WORD_W | Mask word, 1 = compare |
| rpt_addr_en | input | 1 | Address-report option, taken at start |
| srch_start | input | 1 | Begin (or restart) a search pass |
| srch_stop | input | 1 | Abort the running search |
| blk_valid | input | 1 | Stream word valid |
| blk_sop | input | 1 | First word of a block |
| blk_eop | input | 1 | Last word of a block |
| blk_addr | input | AW | Block address, taken with the first word |
| blk_word | input | WORD_W | Stream data word |
| tag_we | input | 1 | Obsolete flag update strobe |
| tag_addr | input | AW | Block whose flag is updated |
| tag_obsolete | input | 1 | 1 = mark obsolete, 0 = clear |
| match_vld | output | 1 | One-cycle match event |
| match_addr | output | AW | Address of the matching block |
| srch_done | output | 1 | Search pass complete |
| free_addr | output | AW | Lowest obsolete block |
| free_none | output | 1 | No obsolete block exists |

## Verification
The bench sweeps a one-nibble field of the first word over all sixteen values so each pass must hit exactly one block, and corrupts a single unmasked bit in the first, a middle and the last word of an otherwise matching pattern; a design that only looked at the last word, or forgot a miss between words, would report those blocks. A permuted pattern catches a design that aligned pattern words with the wrong stream position, and gapped streaming catches one that advanced the word index on idle cycles. The obsolete map is walked by tagging all blocks from the top down and untagging from the bottom up, so a wrong priority direction or a stale free slot shows at once, and a final pass with flags set shows the search ignoring them. Stop and pre-start streaming check that no events leak outside a search and that an aborted pass never raises the completion flag.

// File: rtl/msrch_pkg.sv
package msrch_pkg;

    typedef enum logic [0:0] {
        SRCH_IDLE = 1'b0,
        SRCH_RUN  = 1'b1
    } srch_state_e;

endpackage

// File: rtl/msrch_pattern_regs.sv
module msrch_pattern_regs #(
    parameter int WORD_W    = 16,
    parameter int BLK_WORDS = 4,
    localparam int IDX_W    = $clog2(BLK_WORDS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_we,
    input  logic [IDX_W-1:0]                    cfg_idx,
    input  logic [WORD_W-1:0]                   cfg_pat,
    input  logic [WORD_W-1:0]                   cfg_mask,
    output logic [BLK_WORDS-1:0][WORD_W-1:0]    pat_o,
    output logic [BLK_WORDS-1:0][WORD_W-1:0]    mask_o
);

    logic [BLK_WORDS-1:0][WORD_W-1:0] pat_d, pat_q;
    logic [BLK_WORDS-1:0][WORD_W-1:0] mask_d, mask_q;

    always_comb begin
        pat_d  = pat_q;
        mask_d = mask_q;
        if (cfg_we) begin
            pat_d[cfg_idx]  = cfg_pat;
            mask_d[cfg_idx] = cfg_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q  <= '0;
            mask_q <= '0;
        end else begin
            pat_q  <= pat_d;
            mask_q <= mask_d;
        end
    end

    assign pat_o  = pat_q;
    assign mask_o = mask_q;

    // R3: a configuration write lands in exactly the addressed word position
    p_cfg_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (pat_q[$past(cfg_idx)] == $past(cfg_pat)) &&
                   (mask_q[$past(cfg_idx)] == $past(cfg_mask)));

endmodule

// File: rtl/msrch_compare.sv
module msrch_compare #(
    parameter int WORD_W    = 16,
    parameter int BLK_WORDS = 4,
    parameter int AW        = 4,
    localparam int IDX_W    = $clog2(BLK_WORDS),
    localparam int WIDX_W   = $clog2(BLK_WORDS + 1)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                en_i,
    input  logic                                blk_valid_i,
    input  logic                                blk_sop_i,
    input  logic                                blk_eop_i,
    input  logic [AW-1:0]                       blk_addr_i,
    input  logic [WORD_W-1:0]                   blk_word_i,
    input  logic [BLK_WORDS-1:0][WORD_W-1:0]    pat_i,
    input  logic [BLK_WORDS-1:0][WORD_W-1:0]    mask_i,
    output logic                                res_vld_o,
    output logic                                res_hit_o,
    output logic [AW-1:0]                       res_addr_o
);

    localparam logic [IDX_W-1:0]  LAST_SEL  = IDX_W'(BLK_WORDS - 1);
    localparam logic [WIDX_W-1:0] WORDS_CNT = WIDX_W'(BLK_WORDS);
    localparam logic [WIDX_W-1:0] ONE_CNT   = WIDX_W'(1);

    typedef struct packed {
        logic              in_blk;
        logic              miss;
        logic [WIDX_W-1:0] widx;
        logic [AW-1:0]     addr;
        logic              res_vld;
        logic              res_hit;
        logic [AW-1:0]     res_addr;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic [IDX_W-1:0]  sel;
    logic [WORD_W-1:0] pat_sel;
    logic [WORD_W-1:0] mask_sel;
    logic              word_ok;

    always_comb begin
        if (blk_sop_i) begin
            sel = '0;
        end else if (st_q.widx >= WORDS_CNT) begin
            sel = LAST_SEL;
        end else begin
            sel = st_q.widx[IDX_W-1:0];
        end
        pat_sel  = pat_i[sel];
        mask_sel = mask_i[sel];
        word_ok  = ((blk_word_i ^ pat_sel) & mask_sel) == '0;
    end

    always_comb begin
        st_d         = st_q;
        st_d.res_vld = 1'b0;
        st_d.res_hit = 1'b0;
        if (!en_i) begin
            st_d.in_blk = 1'b0;
        end else if (blk_valid_i) begin
            if (blk_sop_i) begin
                st_d.in_blk = 1'b1;
                st_d.miss   = !word_ok;
                st_d.addr   = blk_addr_i;
                st_d.widx   = ONE_CNT;
            end else if (st_q.in_blk) begin
                st_d.miss = st_q.miss | !word_ok;
                if (st_q.widx < WORDS_CNT) begin
                    st_d.widx = st_q.widx + ONE_CNT;
                end
            end
            if (blk_eop_i && (blk_sop_i || st_q.in_blk)) begin
                st_d.res_vld  = 1'b1;
                st_d.res_hit  = !st_d.miss;
                st_d.res_addr = st_d.addr;
                st_d.in_blk   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_vld_o  = st_q.res_vld;
    assign res_hit_o  = st_q.res_hit;
    assign res_addr_o = st_q.res_addr;

    // R4: a result only appears the cycle after an end-of-block word during a search
    p_result_after_eop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |-> $past(blk_valid_i && blk_eop_i && en_i));

    // R2: a failing word in the closing cycle can never produce a hit
    p_bad_word_no_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid_i && blk_eop_i && en_i && !word_ok) |=> !res_hit_o);

    // R3: the word position never runs past the block length
    p_widx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.widx <= WORDS_CNT);

endmodule

// File: rtl/msrch_obsolete_map.sv
module msrch_obsolete_map #(
    parameter int NUM_BLK = 16,
    localparam int AW     = $clog2(NUM_BLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tag_we,
    input  logic [AW-1:0] tag_addr,
    input  logic          tag_obsolete,
    output logic [AW-1:0] free_addr,
    output logic          free_none
);

    logic [NUM_BLK-1:0] flags_d, flags_q;
    logic [AW-1:0]      first_idx;
    logic               any_set;

    always_comb begin
        flags_d = flags_q;
        if (tag_we) begin
            flags_d[tag_addr] = tag_obsolete;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    // lowest index wins: scan downward so the last assignment is the smallest set index
    always_comb begin
        first_idx = '0;
        any_set   = 1'b0;
        for (int i = NUM_BLK - 1; i >= 0; i--) begin
            if (flags_q[i]) begin
                first_idx = AW'(i);
                any_set   = 1'b1;
            end
        end
    end

    assign free_addr = first_idx;
    assign free_none = !any_set;

    // R8: the offered slot is obsolete and nothing below it is
    p_free_is_obsolete_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !free_none |-> (flags_q[free_addr] &&
                        ((flags_q & ((NUM_BLK'(1) << free_addr) - NUM_BLK'(1))) == '0)));

    // R8: a tag command takes effect on the addressed flag one cycle later
    p_tag_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tag_we |=> flags_q[$past(tag_addr)] == $past(tag_obsolete));

    // R9: no slot offered means an empty map, with a zero address
    p_none_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        free_none |-> ($countones(flags_q) == 0) && (free_addr == '0));

endmodule

// File: rtl/msrch_top.sv
module msrch_top
    import msrch_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int BLK_WORDS = 4,
    parameter int NUM_BLK   = 16,
    localparam int AW       = $clog2(NUM_BLK),
    localparam int IDX_W    = $clog2(BLK_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [WORD_W-1:0] cfg_pat,
    input  logic [WORD_W-1:0] cfg_mask,
    input  logic              rpt_addr_en,
    input  logic              srch_start,
    input  logic              srch_stop,
    input  logic              blk_valid,
    input  logic              blk_sop,
    input  logic              blk_eop,
    input  logic [AW-1:0]     blk_addr,
    input  logic [WORD_W-1:0] blk_word,
    input  logic              tag_we,
    input  logic [AW-1:0]     tag_addr,
    input  logic              tag_obsolete,
    output logic              match_vld,
    output logic [AW-1:0]     match_addr,
    output logic              srch_done,
    output logic [AW-1:0]     free_addr,
    output logic              free_none
);

    localparam logic [AW-1:0] LAST_BLK = AW'(NUM_BLK - 1);
    localparam logic [AW-1:0] ONE_BLK  = AW'(1);

    typedef struct packed {
        srch_state_e   state;
        logic [AW-1:0] blk_cnt;
        logic          done;
        logic          rpt;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;

    logic [BLK_WORDS-1:0][WORD_W-1:0] pat_w;
    logic [BLK_WORDS-1:0][WORD_W-1:0] mask_w;
    logic                             res_vld;
    logic                             res_hit;
    logic [AW-1:0]                    res_addr;
    logic                             run_en;

    msrch_pattern_regs #(
        .WORD_W    (WORD_W),
        .BLK_WORDS (BLK_WORDS)
    ) u_pattern (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_pat  (cfg_pat),
        .cfg_mask (cfg_mask),
        .pat_o    (pat_w),
        .mask_o   (mask_w)
    );

    assign run_en = (ctl_q.state == SRCH_RUN);

    msrch_compare #(
        .WORD_W    (WORD_W),
        .BLK_WORDS (BLK_WORDS),
        .AW        (AW)
    ) u_compare (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (run_en),
        .blk_valid_i (blk_valid),
        .blk_sop_i   (blk_sop),
        .blk_eop_i   (blk_eop),
        .blk_addr_i  (blk_addr),
        .blk_word_i  (blk_word),
        .pat_i       (pat_w),
        .mask_i      (mask_w),
        .res_vld_o   (res_vld),
        .res_hit_o   (res_hit),
        .res_addr_o  (res_addr)
    );

    msrch_obsolete_map #(
        .NUM_BLK (NUM_BLK)
    ) u_obsolete (
        .clk          (clk),
        .rst_n        (rst_n),
        .tag_we       (tag_we),
        .tag_addr     (tag_addr),
        .tag_obsolete (tag_obsolete),
        .free_addr    (free_addr),
        .free_none    (free_none)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (srch_start) begin
            ctl_d.state   = SRCH_RUN;
            ctl_d.blk_cnt = '0;
            ctl_d.done    = 1'b0;
            ctl_d.rpt     = rpt_addr_en;
        end else if (srch_stop) begin
            ctl_d.state = SRCH_IDLE;
        end else if (run_en && res_vld) begin
            if (ctl_q.blk_cnt == LAST_BLK) begin
                ctl_d.state = SRCH_IDLE;
                ctl_d.done  = 1'b1;
            end else begin
                ctl_d.blk_cnt = ctl_q.blk_cnt + ONE_BLK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: SRCH_IDLE, blk_cnt: '0, done: 1'b0, rpt: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign match_vld  = res_vld && res_hit;
    assign match_addr = ctl_q.rpt ? res_addr : '0;
    assign srch_done  = ctl_q.done;

    // R7: match events only come from blocks that closed while a search ran
    p_no_match_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_vld |-> $past(run_en));

    // R6: completion is raised only by a compared block, and the engine is then idle
    p_done_from_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srch_done) |-> ($past(res_vld) && !run_en));

    // R6: a start always clears completion
    p_start_clears_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        srch_start |=> !srch_done && run_en);

    // R5: with the report option off the address output stays zero
    p_addr_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vld && !ctl_q.rpt) |-> (match_addr == '0));

endmodule

// File: tb/msrch_top_tb_top.sv
module msrch_top_tb_top;

    localparam int WORD_W = 16;
    localparam int BW     = 4;
    localparam int NB     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_idx = '0;
    logic [WORD_W-1:0] cfg_pat = '0;
    logic [WORD_W-1:0] cfg_mask = '0;
    logic              rpt_addr_en = 1'b0;
    logic              srch_start = 1'b0;
    logic              srch_stop = 1'b0;
    logic              blk_valid = 1'b0;
    logic              blk_sop = 1'b0;
    logic              blk_eop = 1'b0;
    logic [3:0]        blk_addr = '0;
    logic [WORD_W-1:0] blk_word = '0;
    logic              tag_we = 1'b0;
    logic [3:0]        tag_addr = '0;
    logic              tag_obsolete = 1'b0;
    logic              match_vld;
    logic [3:0]        match_addr;
    logic              srch_done;
    logic [3:0]        free_addr;
    logic              free_none;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [WORD_W-1:0] pat_m [BW];
    logic [WORD_W-1:0] msk_m [BW];

    int hit_cnt [NB];
    int r4_bad = 0;
    logic prev_eop = 1'b0;

    always #5 clk = ~clk;

    msrch_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_pat(cfg_pat), .cfg_mask(cfg_mask), .rpt_addr_en(rpt_addr_en),
        .srch_start(srch_start), .srch_stop(srch_stop), .blk_valid(blk_valid),
        .blk_sop(blk_sop), .blk_eop(blk_eop), .blk_addr(blk_addr),
        .blk_word(blk_word), .tag_we(tag_we), .tag_addr(tag_addr),
        .tag_obsolete(tag_obsolete), .match_vld(match_vld),
        .match_addr(match_addr), .srch_done(srch_done),
        .free_addr(free_addr), .free_none(free_none)
    );

    initial begin
        for (int i = 0; i < NB; i++) hit_cnt[i] = 0;
    end

    // monitor: sole writer of the event counters, samples away from the edge
    always @(negedge clk) begin
        if (rst_n && match_vld) begin
            hit_cnt[match_addr] = hit_cnt[match_addr] + 1;
            if (!prev_eop) r4_bad = r4_bad + 1;
        end
        prev_eop = blk_valid && blk_eop;
    end

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 100000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            finish_sim();
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] bdata(input int a, input int k);
        logic [7:0] low;
        low = 8'(a * 29 + k * 7);
        return {4'(a), 4'(k), low};
    endfunction

    function automatic logic [NB-1:0] exp_hits();
        logic [NB-1:0] r;
        r = '0;
        for (int a = 0; a < NB; a++) begin
            bit ok;
            ok = 1'b1;
            for (int k = 0; k < BW; k++)
                if (((bdata(a, k) ^ pat_m[k]) & msk_m[k]) != '0) ok = 1'b0;
            r[a] = ok;
        end
        return r;
    endfunction

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic load_cfg();
        for (int k = 0; k < BW; k++) begin
            tick();
            cfg_we = 1'b1; cfg_idx = 2'(k); cfg_pat = pat_m[k]; cfg_mask = msk_m[k];
        end
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic send_block(input int a, input bit gap);
        for (int k = 0; k < BW; k++) begin
            tick();
            blk_valid = 1'b1; blk_sop = (k == 0); blk_eop = (k == BW - 1);
            blk_addr = 4'(a); blk_word = bdata(a, k);
            if (gap) begin
                tick();
                blk_valid = 1'b0; blk_sop = 1'b0; blk_eop = 1'b0;
            end
        end
        tick();
        blk_valid = 1'b0; blk_sop = 1'b0; blk_eop = 1'b0;
    endtask

    task automatic start_pulse(input bit rpt);
        tick();
        srch_start = 1'b1; rpt_addr_en = rpt;
        tick();
        srch_start = 1'b0;
    endtask

    task automatic snap(output int s [NB]);
        @(negedge clk);
        for (int i = 0; i < NB; i++) s[i] = hit_cnt[i];
    endtask

    // full pass; returns observed per-address event mask and total events
    task automatic run_pass(input bit rpt, input bit gap, output logic [NB-1:0] seen, output int total, output int at0);
        int s [NB];
        snap(s);
        start_pulse(rpt);
        for (int a = 0; a < NB; a++) begin
            if (!gap) begin
                // back-to-back: no idle cycle between blocks
                for (int k = 0; k < BW; k++) begin
                    tick();
                    blk_valid = 1'b1; blk_sop = (k == 0); blk_eop = (k == BW - 1);
                    blk_addr = 4'(a); blk_word = bdata(a, k);
                end
            end else begin
                send_block(a, 1'b1);
            end
        end
        tick();
        blk_valid = 1'b0; blk_sop = 1'b0; blk_eop = 1'b0;
        repeat (3) tick();
        @(negedge clk);
        seen = '0; total = 0;
        for (int i = 0; i < NB; i++) begin
            int d;
            d = hit_cnt[i] - s[i];
            total = total + d;
            if (d != 0) seen[i] = 1'b1;
        end
        at0 = hit_cnt[0] - s[0];
    endtask

    initial begin
        logic [NB-1:0] seen;
        logic [NB-1:0] ex;
        int total, at0;

        repeat (3) tick();
        @(negedge clk);
        // R11: reset state
        check(match_vld == 1'b0 && srch_done == 1'b0, "R11", {match_vld, srch_done}, 0);
        check(free_none == 1'b1 && free_addr == '0, "R11/R9", {free_none, free_addr}, 32'h10);
        rst_n = 1'b1;
        repeat (2) tick();

        // R7: block streamed before any start produces no event
        for (int k = 0; k < BW; k++) begin pat_m[k] = '0; msk_m[k] = '0; end
        load_cfg();
        begin
            int s [NB];
            int tot;
            snap(s);
            send_block(2, 1'b0);
            repeat (3) tick();
            @(negedge clk);
            tot = 0;
            for (int i = 0; i < NB; i++) tot = tot + hit_cnt[i] - s[i];
            check(tot == 0, "R7 idle stream", tot, 0);
            check(srch_done == 1'b0, "R7 idle done", srch_done, 0);
        end

        // R1: all-zero mask matches every block
        run_pass(1'b1, 1'b0, seen, total, at0);
        check(seen == {NB{1'b1}} && total == NB, "R1 zero mask", seen, {NB{1'b1}});
        check(srch_done == 1'b1, "R6 done after pass", srch_done, 1);
        check(r4_bad == 0, "R4 back-to-back timing", r4_bad, 0);

        // R6: done held, then cleared by the next start
        repeat (5) tick();
        @(negedge clk);
        check(srch_done == 1'b1, "R6 done held", srch_done, 1);
        start_pulse(1'b1);
        @(negedge clk);
        check(srch_done == 1'b0, "R6 start clears", srch_done, 0);
        tick();
        srch_stop = 1'b1;
        tick();
        srch_stop = 1'b0;

        // R1/R5: field sweep over the address nibble of word 0
        for (int v = 0; v < NB; v++) begin
            for (int k = 0; k < BW; k++) begin pat_m[k] = '0; msk_m[k] = '0; end
            pat_m[0] = {4'(v), 12'h000};
            msk_m[0] = 16'hF000;
            load_cfg();
            ex = exp_hits();
            run_pass(1'b1, 1'b0, seen, total, at0);
            check(seen == ex && total == 1, "R1/R5 field sweep", seen, ex);
        end

        // R2: full-mask pattern of block 5, then single-bit errors in word 0, 2, 3
        for (int k = 0; k < BW; k++) begin pat_m[k] = bdata(5, k); msk_m[k] = 16'hFFFF; end
        load_cfg();
        run_pass(1'b1, 1'b0, seen, total, at0);
        check(seen == 16'h0020 && total == 1, "R2 exact block", seen, 16'h0020);
        for (int w = 0; w < BW; w++) begin
            if (w == 1) continue;
            for (int k = 0; k < BW; k++) begin pat_m[k] = bdata(5, k); msk_m[k] = 16'hFFFF; end
            pat_m[w] = pat_m[w] ^ 16'h0001;
            load_cfg();
            run_pass(1'b1, 1'b0, seen, total, at0);
            check(total == 0, "R2 one bad word", total, 0);
        end
        // same corrupted bit but masked off: match returns
        for (int k = 0; k < BW; k++) begin pat_m[k] = bdata(5, k); msk_m[k] = 16'hFFFF; end
        pat_m[2] = pat_m[2] ^ 16'h0001;
        msk_m[2] = 16'hFFFE;
        load_cfg();
        run_pass(1'b1, 1'b0, seen, total, at0);
        check(seen == 16'h0020, "R1 masked bad bit", seen, 16'h0020);

        // R3: reversed word order must not match; gapped stream must still match
        for (int k = 0; k < BW; k++) begin pat_m[k] = bdata(9, BW - 1 - k); msk_m[k] = 16'hFFFF; end
        load_cfg();
        ex = exp_hits();
        run_pass(1'b1, 1'b0, seen, total, at0);
        check(seen == ex && total == 0, "R3 reversed order", seen, ex);
        for (int k = 0; k < BW; k++) begin pat_m[k] = bdata(9, k); msk_m[k] = 16'h0FFF; end
        load_cfg();
        run_pass(1'b1, 1'b1, seen, total, at0);
        check(seen == 16'h0200 && total == 1, "R3/R4 gapped stream", seen, 16'h0200);
        check(r4_bad == 0, "R4 event follows eop", r4_bad, 0);

        // R5: report option off, every event carries address 0
        for (int k = 0; k < BW; k++) begin pat_m[k] = '0; msk_m[k] = '0; end
        pat_m[1] = 16'h0100; msk_m[1] = 16'h0F00;
        msk_m[0] = 16'h1000;
        load_cfg();
        ex = exp_hits();
        run_pass(1'b0, 1'b0, seen, total, at0);
        check(at0 == $countones(ex) && total == $countones(ex), "R5 address hidden", at0, $countones(ex));

        // R7: stop after six blocks, rest ignored, no done
        for (int k = 0; k < BW; k++) begin pat_m[k] = '0; msk_m[k] = '0; end
        load_cfg();
        begin
            int s [NB];
            int tot;
            logic [NB-1:0] sm;
            snap(s);
            start_pulse(1'b1);
            for (int a = 0; a < 6; a++) send_block(a, 1'b0);
            tick();
            srch_stop = 1'b1;
            tick();
            srch_stop = 1'b0;
            for (int a = 6; a < NB; a++) send_block(a, 1'b0);
            repeat (3) tick();
            @(negedge clk);
            tot = 0; sm = '0;
            for (int i = 0; i < NB; i++) begin
                tot = tot + hit_cnt[i] - s[i];
                if (hit_cnt[i] != s[i]) sm[i] = 1'b1;
            end
            check(sm == 16'h003F && tot == 6, "R7 stop", sm, 16'h003F);
            check(srch_done == 1'b0, "R7 no done after stop", srch_done, 0);
        end

        // R8: tag from top down, lowest obsolete is offered
        for (int i = NB - 1; i >= 0; i--) begin
            tick();
            tag_we = 1'b1; tag_addr = 4'(i); tag_obsolete = 1'b1;
            tick();
            tag_we = 1'b0;
            @(negedge clk);
            check(free_addr == 4'(i) && !free_none, "R8 tag sweep", free_addr, i);
        end
        // R8/R9: untag from bottom up
        for (int i = 0; i < NB; i++) begin
            tick();
            tag_we = 1'b1; tag_addr = 4'(i); tag_obsolete = 1'b0;
            tick();
            tag_we = 1'b0;
            @(negedge clk);
            if (i < NB - 1)
                check(free_addr == 4'(i + 1) && !free_none, "R8 untag sweep", free_addr, i + 1);
            else
                check(free_none && free_addr == '0, "R9 empty map", {free_none, free_addr}, 32'h10);
        end

        // R10: obsolete blocks still found by content
        tick();
        tag_we = 1'b1; tag_addr = 4'd9; tag_obsolete = 1'b1;
        tick();
        tag_addr = 4'd3;
        tick();
        tag_we = 1'b0;
        for (int k = 0; k < BW; k++) begin pat_m[k] = bdata(9, k); msk_m[k] = 16'hFFFF; end
        load_cfg();
        run_pass(1'b1, 1'b0, seen, total, at0);
        check(seen == 16'h0200 && total == 1, "R10 obsolete searched", seen, 16'h0200);
        check(free_addr == 4'd3 && !free_none, "R8 free after search", free_addr, 3);

        finish_sim();
    end

endmodule